// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is a hardware master for the two-wire management bus between an Ethernet MAC and a PHY. It generates the management clock (MDC) from the system clock through a fixed divider. It drives or releases the bidirectional data line through separate output, output-enable and input signals, so the actual pad buffer stays outside the block.

A one-cycle request launches a whole frame. The request carries a read/write flag, a 5-bit PHY address, a 5-bit register address and 16 bits of write data. Every frame has these parts in order:

- a long run of ones (the preamble);
- the start and opcode fields;
- the two addresses;
- a turnaround;
- 16 data bits;
- one trailing clock with the line released.

Write frames drive their turnaround themselves. On a read, the master releases the line and shifts the PHY's reply into a result register. When the frame ends, a single-cycle completion strobe is raised and the busy flag falls.

Top module: `mdio_master`

## Requirements
- R1: After reset and whenever no frame is in progress, `mdc_o` is 0, `mdio_oe_o` is 0 and `busy_o` is 0.
- R2: A frame begins with PRE_LEN (default 40) MDC clocks during which `mdio_oe_o` is 1 and `mdio_o` is 1 at every rising edge of MDC.
- R3: After the preamble, the master drives a start field of 0 then 1, followed by an opcode of 1,0 for a read (`rd_i`=1) or 0,1 for a write (`rd_i`=0).
- R4: After the opcode, the master drives `phy_addr_i` and then `reg_addr_i`, each as 5 bits, most significant bit first.
- R5: `mdio_o` and `mdio_oe_o` change only while MDC is low. They never change in a cycle where MDC rises or stays high.
- R6: Each MDC half-period, high or low, lasts exactly HALF_DIV system clock cycles. The first low half starts in the cycle after the request is accepted.
- R7: On a write, after the register address, the master drives a turnaround of 1 then 0, then the 16 bits of `wdata_i` most significant bit first. The frame has 73 MDC rising edges in total.
- R8: On a read, `mdio_oe_o` falls right after the register address. One turnaround clock follows, then 16 clocks. MDIO is sampled when MDC falls at the end of each of those 16 clocks, and the bits are assembled most significant bit first into `rdata_o`. The frame has 72 MDC rising edges in total.
- R9: After the data bits of either frame type, the line stays released and exactly one more MDC pulse occurs before the frame ends.
- R10: `busy_o` rises in the cycle after an accepted request. `done_o` is high for exactly one cycle, namely the first cycle in which `busy_o` is low again.
- R11: A request while `busy_o` is 1 has no effect: the frame in progress keeps its bits and length, and no further frame follows it.
- R12: `rdata_o` changes only when a read frame completes. Write frames leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Frame request, sampled when idle |
| rd_i | input | 1 | 1 = read frame, 0 = write frame |
| phy_addr_i | input | 5 | Target PHY address |
| reg_addr_i | input | 5 | Target register address |
| wdata_i | input | 16 | Data for a write frame |
| busy_o | output | 1 | A frame is in progress |
| done_o | output | 1 | One-cycle end-of-frame strobe |
| rdata_o | output | 16 | Result of the last completed read |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe_o | output | 1 | Data line driver enable |
| mdio_i | input | 1 | Data line input from the pad |

## Verification
The properties assume that HALF_DIV is larger than the input synchronizer depth plus one. This ensures that a PHY answer appearing after an MDC rise has passed the synchronizer before the following fall. The stimulus respects this by driving `mdio_i` from the bench's PHY model in the sample right after it sees each rising edge, and holding it until the next rise. The properties also assume that `mdio_i` carries a defined value. The bench never leaves it unknown. Requests are pulsed only from an idle block, except for deliberate mid-frame requests that exercise the ignore rule.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int ADDR_W  = 5;
    localparam int DATA_W  = 16;
    localparam int HDR_LEN = 4 + 2 * ADDR_W;
    localparam int TX_W    = DATA_W + 2;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRE,
        PH_HDR,
        PH_TA,
        PH_DATA,
        PH_TAIL
    } phase_e;
endpackage

// File: rtl/mdio_tick_gen.sv
module mdio_tick_gen #(
    parameter int HALF_DIV = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!run_i || cnt_q == LAST) cnt_d = '0;
        else                         cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/mdio_in_sync.sv
module mdio_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_pkg::*;
#(
    parameter int PRE_LEN = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              mdio_s_i,
    input  logic              start_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] phy_addr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              mdc_o,
    output logic              mdio_o,
    output logic              mdio_oe_o
);
    localparam int MAXLEN = (PRE_LEN > TX_W) ? PRE_LEN : TX_W;
    localparam int CNT_W  = $clog2(MAXLEN) + 1;
    localparam int PAD_W  = TX_W - HDR_LEN;

    typedef struct packed {
        phase_e            phase;
        logic [CNT_W-1:0]  cnt;
        logic [TX_W-1:0]   sh;
        logic [DATA_W-1:0] wd;
        logic [DATA_W-1:0] rx;
        logic [DATA_W-1:0] rdata;
        logic              rd;
        logic              mdc;
        logic              mdo;
        logic              oe;
        logic              busy;
        logic              done;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;

        if (st_q.phase == PH_IDLE) begin
            if (start_i) begin
                st_d.phase = PH_PRE;
                st_d.cnt   = CNT_W'(PRE_LEN - 1);
                st_d.sh    = {2'b01, rd_i, !rd_i, phy_addr_i, reg_addr_i, {PAD_W{1'b0}}};
                st_d.wd    = wdata_i;
                st_d.rd    = rd_i;
                st_d.busy  = 1'b1;
                st_d.mdc   = 1'b0;
            end
        end else if (tick_i) begin
            if (!st_q.mdc) begin
                st_d.mdc = 1'b1;
            end else begin
                st_d.mdc = 1'b0;
                case (st_q.phase)
                    PH_PRE: begin
                        if (st_q.cnt == '0) begin
                            st_d.phase = PH_HDR;
                            st_d.cnt   = CNT_W'(HDR_LEN - 1);
                        end else begin
                            st_d.cnt = st_q.cnt - 1'b1;
                        end
                    end
                    PH_HDR: begin
                        if (st_q.cnt != '0) begin
                            st_d.cnt = st_q.cnt - 1'b1;
                            st_d.sh  = {st_q.sh[TX_W-2:0], 1'b0};
                        end else if (st_q.rd) begin
                            st_d.phase = PH_TA;
                            st_d.cnt   = '0;
                        end else begin
                            st_d.phase = PH_DATA;
                            st_d.sh    = {2'b10, st_q.wd};
                            st_d.cnt   = CNT_W'(TX_W - 1);
                        end
                    end
                    PH_TA: begin
                        st_d.phase = PH_DATA;
                        st_d.cnt   = CNT_W'(DATA_W - 1);
                    end
                    PH_DATA: begin
                        if (st_q.rd) st_d.rx = {st_q.rx[DATA_W-2:0], mdio_s_i};
                        else         st_d.sh = {st_q.sh[TX_W-2:0], 1'b0};
                        if (st_q.cnt == '0) st_d.phase = PH_TAIL;
                        else                st_d.cnt   = st_q.cnt - 1'b1;
                    end
                    PH_TAIL: begin
                        st_d.phase = PH_IDLE;
                        st_d.busy  = 1'b0;
                        st_d.done  = 1'b1;
                        if (st_q.rd) st_d.rdata = st_q.rx;
                    end
                    default: st_d.phase = PH_IDLE;
                endcase
            end
        end

        st_d.oe  = (st_d.phase == PH_PRE) || (st_d.phase == PH_HDR) ||
                   ((st_d.phase == PH_DATA) && !st_d.rd);
        st_d.mdo = (st_d.phase == PH_PRE) ? 1'b1 : (st_d.oe && st_d.sh[TX_W-1]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o    = st_q.busy;
    assign done_o    = st_q.done;
    assign rdata_o   = st_q.rdata;
    assign mdc_o     = st_q.mdc;
    assign mdio_o    = st_q.mdo;
    assign mdio_oe_o = st_q.oe;
endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
    parameter int HALF_DIV    = 20,
    parameter int PRE_LEN     = 40,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        rd_i,
    input  logic [4:0]  phy_addr_i,
    input  logic [4:0]  reg_addr_i,
    input  logic [15:0] wdata_i,
    output logic        busy_o,
    output logic        done_o,
    output logic [15:0] rdata_o,
    output logic        mdc_o,
    output logic        mdio_o,
    output logic        mdio_oe_o,
    input  logic        mdio_i
);
    logic tick;
    logic mdio_s;
    logic busy_int;

    mdio_in_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (mdio_i),
        .q_o   (mdio_s)
    );

    mdio_tick_gen #(.HALF_DIV(HALF_DIV)) tick_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (busy_int),
        .tick_o (tick)
    );

    mdio_frame_seq #(.PRE_LEN(PRE_LEN)) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .mdio_s_i   (mdio_s),
        .start_i    (start_i),
        .rd_i       (rd_i),
        .phy_addr_i (phy_addr_i),
        .reg_addr_i (reg_addr_i),
        .wdata_i    (wdata_i),
        .busy_o     (busy_int),
        .done_o     (done_o),
        .rdata_o    (rdata_o),
        .mdc_o      (mdc_o),
        .mdio_o     (mdio_o),
        .mdio_oe_o  (mdio_oe_o)
    );

    assign busy_o = busy_int;
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
    parameter int HALF_DIV = 20
) (
    input logic        clk,
    input logic        rst_n,
    input logic        busy_o,
    input logic        done_o,
    input logic [15:0] rdata_o,
    input logic        mdc_o,
    input logic        mdio_o,
    input logic        mdio_oe_o
);
    localparam int HW = $clog2(HALF_DIV + 1) + 1;

    logic          mdc_prev_q;
    logic [HW-1:0] half_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mdc_prev_q <= 1'b0;
            half_q     <= '0;
        end else begin
            mdc_prev_q <= mdc_o;
            if (mdc_o != mdc_prev_q) half_q <= HW'(1);
            else if (!busy_o)        half_q <= '0;
            else                     half_q <= half_q + 1'b1;
        end
    end

    assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!mdc_o && !mdio_oe_o));

    assert_line_quiet_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mdc_o |-> ($stable(mdio_o) && $stable(mdio_oe_o)));

    assert_half_period_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc_o != mdc_prev_q) |-> (half_q == HW'(HALF_DIV)));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_ends_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> ($fell(busy_o)));

    assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(rdata_o));
endmodule

bind mdio_master mdio_master_chk #(.HALF_DIV(HALF_DIV)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .rdata_o   (rdata_o),
    .mdc_o     (mdc_o),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o)
);

// File: tb/mdio_master_tb_top.sv
module mdio_master_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 20;
    localparam int PRE        = 40;
    localparam int MAXS       = 80;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        rd_i = 1'b0;
    logic [4:0]  phy_addr_i = '0;
    logic [4:0]  reg_addr_i = '0;
    logic [15:0] wdata_i = '0;
    logic        busy_o, done_o, mdc_o, mdio_o, mdio_oe_o;
    logic [15:0] rdata_o;
    logic        mdio_i = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdio_master #(.HALF_DIV(HALF), .PRE_LEN(PRE)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_i(rd_i),
        .phy_addr_i(phy_addr_i), .reg_addr_i(reg_addr_i), .wdata_i(wdata_i),
        .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o),
        .mdc_o(mdc_o), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o), .mdio_i(mdio_i)
    );

    typedef struct {
        bit          rd;
        int          n;
        logic [15:0] rv;
        logic [15:0] rdata;
        logic        ev [MAXS];
        logic        eo [MAXS];
    } item_t;

    item_t       exp_q [$];
    int          checks = 0;
    int          failures = 0;
    logic [15:0] last_rd = '0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // Driver: builds the expected slot stream and launches a frame
    task automatic do_frame(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                            input logic [15:0] wd, input logic [15:0] rv, input bit poke);
        item_t it;
        int    k = 0;
        logic [17:0] hdr;
        it.rd = rd;
        it.rv = rv;
        for (int i = 0; i < MAXS; i++) begin it.ev[i] = 1'b0; it.eo[i] = 1'b0; end
        for (int i = 0; i < PRE; i++) begin it.ev[k] = 1'b1; it.eo[k] = 1'b1; k++; end
        hdr = {4'b0, 2'b01, rd, !rd, pa, ra};
        for (int i = 13; i >= 0; i--) begin it.ev[k] = hdr[i]; it.eo[k] = 1'b1; k++; end
        if (!rd) begin
            it.ev[k] = 1'b1; it.eo[k] = 1'b1; k++;
            it.ev[k] = 1'b0; it.eo[k] = 1'b1; k++;
            for (int i = 15; i >= 0; i--) begin it.ev[k] = wd[i]; it.eo[k] = 1'b1; k++; end
        end else begin
            k += 17;
        end
        k++;
        it.n = k;
        it.rdata = rd ? rv : last_rd;
        if (rd) last_rd = rv;
        exp_q.push_back(it);

        @(negedge clk);
        start_i = 1'b1; rd_i = rd; phy_addr_i = pa; reg_addr_i = ra; wdata_i = wd;
        @(negedge clk);
        start_i = 1'b0;
        if (poke) begin
            repeat (HALF * 30) @(negedge clk);
            start_i = 1'b1; rd_i = !rd; phy_addr_i = ~pa; reg_addr_i = ~ra; wdata_i = ~wd;
            @(negedge clk);
            start_i = 1'b0;
            repeat (HALF * 40) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (!done_o) @(negedge clk);
        repeat (HALF * 4) @(negedge clk);
        check(!busy_o && !mdc_o && !mdio_oe_o, "R11", "block idle after frame",
              {busy_o, mdc_o, mdio_oe_o}, 0);
    endtask

    // Monitor: records every MDC rise and compares at the end of the frame
    logic got_ev [MAXS];
    logic got_eo [MAXS];
    int   idx = 0;
    int   hcnt = 0;
    bit   in_frame = 0;
    bit   half_bad = 0;
    bit   moved_bad = 0;
    logic p_mdc = 0, p_mdo = 0, p_oe = 0, p_busy = 0, p_done = 0;

    function automatic int range_bad(input item_t it, input int lo, input int hi);
        int b = 0;
        for (int i = lo; i <= hi; i++)
            if (got_eo[i] !== it.eo[i] || (it.eo[i] && got_ev[i] !== it.ev[i])) b++;
        return b;
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            if (p_done) check(!done_o, "R10", "done lasts one cycle", done_o, 0);
            if (busy_o && !p_busy) begin
                in_frame = 1; idx = 0; hcnt = 0; half_bad = 0; moved_bad = 0;
            end else if (in_frame) begin
                hcnt++;
                if (mdc_o != p_mdc) begin
                    if (hcnt != HALF) half_bad = 1;
                    hcnt = 0;
                end
                if (mdc_o && (mdio_o != p_mdo || mdio_oe_o != p_oe)) moved_bad = 1;
                if (mdc_o && !p_mdc) begin
                    if (idx < MAXS) begin got_ev[idx] = mdio_o; got_eo[idx] = mdio_oe_o; end
                    idx++;
                    if (exp_q.size() > 0 && exp_q[0].rd && idx >= PRE + 16 && idx <= PRE + 31)
                        mdio_i = exp_q[0].rv[PRE + 31 - idx];
                    else
                        mdio_i = 1'b0;
                end
            end
            if (done_o && in_frame) begin
                in_frame = 0;
                check(!busy_o && p_busy, "R10", "busy falls with done", busy_o, 0);
                if (exp_q.size() == 0) begin
                    check(0, "R11", "unexpected frame", idx, 0);
                end else begin
                    item_t it;
                    int    hb;
                    it = exp_q.pop_front();
                    check(idx == it.n, it.rd ? "R8" : "R7", "MDC rising edges", idx, it.n);
                    if (idx == it.n) begin
                        hb = it.rd ? 54 : 55;
                        check(range_bad(it, 0, PRE - 1) == 0, "R2", "preamble slots",
                              range_bad(it, 0, PRE - 1), 0);
                        check(range_bad(it, PRE, PRE + 3) == 0, "R3", "start/opcode slots",
                              range_bad(it, PRE, PRE + 3), 0);
                        check(range_bad(it, PRE + 4, PRE + 13) == 0, "R4", "address slots",
                              range_bad(it, PRE + 4, PRE + 13), 0);
                        check(range_bad(it, PRE + 14, it.n - 2) == 0, it.rd ? "R8" : "R7",
                              "turnaround/data slots", range_bad(it, PRE + 14, it.n - 2), 0);
                        check(range_bad(it, it.n - 1, it.n - 1) == 0, "R9", "trailing released clock",
                              got_eo[it.n - 1], 0);
                        if (hb < 0) check(0, "R8", "unreachable", 0, 0);
                    end
                    check(rdata_o === it.rdata, it.rd ? "R8" : "R12", "read data", rdata_o, it.rdata);
                    check(!half_bad, "R6", "half period length", half_bad, 0);
                    check(!moved_bad, "R5", "line changed while MDC high", moved_bad, 0);
                end
            end
        end
        p_mdc = mdc_o; p_mdo = mdio_o; p_oe = mdio_oe_o; p_busy = busy_o; p_done = done_o;
    end

    bit finished = 0;

    initial begin
        repeat (5) @(negedge clk);
        check(!busy_o && !mdc_o && !mdio_oe_o && !done_o, "R1", "outputs in reset",
              {busy_o, mdc_o, mdio_oe_o, done_o}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(!busy_o && !mdc_o && !mdio_oe_o && rdata_o == 16'h0, "R1", "idle after reset",
              {busy_o, mdc_o, mdio_oe_o}, 0);
        do_frame(1'b1, 5'h01, 5'h02, 16'h0000, 16'hA5C3, 1'b0);
        do_frame(1'b0, 5'h15, 5'h0A, 16'h1234, 16'h0000, 1'b0);   // R12 write keeps rdata
        do_frame(1'b1, 5'h1F, 5'h1F, 16'h0000, 16'hFFFF, 1'b0);
        do_frame(1'b0, 5'h00, 5'h00, 16'h0000, 16'h0000, 1'b1);   // R11 mid-frame requests
        do_frame(1'b1, 5'h0A, 5'h15, 16'h0000, 16'h8001, 1'b1);   // R11 on a read
        do_frame(1'b0, 5'h1F, 5'h10, 16'hFFFF, 16'h0000, 1'b0);
        do_frame(1'b1, 5'h00, 5'h00, 16'h0000, 16'h0000, 1'b0);
        check(exp_q.size() == 0, "R11", "all frames completed", exp_q.size(), 0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog R10 actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule